// File: doc/BRIEF.md
# Selectable Oscillator Glitch Filter

This block removes short noise pulses from a raw oscillator signal. A fast sampling clock oversamples the raw input through a two-stage synchronizer. A level change reaches the output only after the new level has held for a minimum number of sample cycles. Shorter high or low excursions are dropped. The block is meant to sit between an oscillator input pad and the clock tree of a slow core.

A width select picks one of two rejection windows. The short window suits an 8 MHz oscillator and the long window suits a 4 MHz one. With a 200 MHz sampling clock, the short window is 8 samples (40 ns), so anything faster than 12.5 MHz is rejected. The long window is 16 samples (80 ns), so anything faster than 6.25 MHz is rejected. An active-low enable switches the filter on. When the enable is deasserted, the raw input goes straight to the output.

Top module: `osc_glitch_filter`

## Requirements
- R1: While reset is asserted and after it is released, the filtered level is low and the run counter is zero. With the filter enabled and the input held low, the output stays low.
- R2: With `wide_sel_i` = 0, a new input level that holds for 8 consecutive sample edges is passed to the output. If the input changes before rising edge k, the output changes right after edge k+9 (2 synchronizer edges plus 8 counting edges).
- R3: With `wide_sel_i` = 0, a high pulse of 7 sample cycles or fewer produces no change at the output.
- R4: With `wide_sel_i` = 1, a level that holds for 16 sample edges is passed, with the output changing after edge k+17. A pulse of 15 cycles or fewer is dropped.
- R5: If the synchronized input returns to the output level before the window is reached, the count clears. A following excursion must then hold for the full window again, so 5 high, 1 low and 5 high under the short window give no output change.
- R6: When `filt_en_ni` = 1, `osc_clk_o` equals `osc_raw_i` with no clock delay. When `filt_en_ni` = 0, `osc_clk_o` is the filtered level.
- R7: A change of `wide_sel_i` during a count takes effect on the next edge. If the count already meets the new, shorter window, the output flips on that edge.
- R8: Low pulses are filtered in the same way as high pulses. From a high output, a 7-cycle low pulse under the short window is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock (200 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_raw_i | input | 1 | Raw, asynchronous oscillator level |
| wide_sel_i | input | 1 | 0: 8-sample window, 1: 16-sample window |
| filt_en_ni | input | 1 | 0: filter on, 1: bypass raw input to the output |
| osc_clk_o | output | 1 | Filtered oscillator level |

## Verification
With the filter enabled, a level that the bench drives before rising edge k becomes visible at the output just after edge k+9 in the short window, or just after edge k+17 in the long one. In bypass the output follows the input within the same cycle. A behavioural reference model is stepped on every rising edge and compared 1 ns later, so each edge's register updates have settled before the comparison. The directed checks count falling edges from the moment of the drive to reach the exact due cycle. Edge counters on the output show whether a dropped pulse left any trace.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;
  parameter int unsigned DEF_NARROW_CYC = 8;
  parameter int unsigned DEF_WIDE_CYC   = 16;
  parameter int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic {
    WIN_NARROW = 1'b0,
    WIN_WIDE   = 1'b1
  } win_sel_e;
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gf_win_sel.sv
module gf_win_sel
  import glitch_filter_pkg::*;
#(
  parameter int unsigned NARROW_CYC = DEF_NARROW_CYC,
  parameter int unsigned WIDE_CYC   = DEF_WIDE_CYC,
  localparam int unsigned CW = $clog2(WIDE_CYC)
) (
  input  logic          sel_i,
  output logic [CW-1:0] lim_o
);
  localparam logic [CW-1:0] NARROW_LIM = CW'(NARROW_CYC - 1);
  localparam logic [CW-1:0] WIDE_LIM   = CW'(WIDE_CYC - 1);

  always_comb begin
    unique case (win_sel_e'(sel_i))
      WIN_WIDE: lim_o = WIDE_LIM;
      default:  lim_o = NARROW_LIM;
    endcase
  end
endmodule

// File: rtl/gf_filter.sv
module gf_filter
  import glitch_filter_pkg::*;
#(
  parameter int unsigned NARROW_CYC = DEF_NARROW_CYC,
  parameter int unsigned WIDE_CYC   = DEF_WIDE_CYC,
  localparam int unsigned CW = $clog2(WIDE_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic [CW-1:0] lim_i,
  output logic          filt_o
);
  logic          filt_q;
  logic [CW-1:0] cnt_q;
  logic          differ;
  logic          reach;

  assign differ = sync_i ^ filt_q;
  // >= so a shrinking window mid-count flips at once
  assign reach  = (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!differ) begin
      cnt_q  <= '0;
    end else if (reach) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  assert_flip_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> $past(sync_i != filt_q));

  assert_min_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(cnt_q) >= CW'(NARROW_CYC - 1)));

  assert_match_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i == filt_q) |=> (cnt_q == '0));

  assert_flip_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> (cnt_q == '0));

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < WIDE_CYC);
endmodule

// File: rtl/osc_glitch_filter.sv
module osc_glitch_filter
  import glitch_filter_pkg::*;
#(
  parameter int unsigned NARROW_CYC  = DEF_NARROW_CYC,
  parameter int unsigned WIDE_CYC    = DEF_WIDE_CYC,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned CW = $clog2(WIDE_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_raw_i,
  input  logic wide_sel_i,
  input  logic filt_en_ni,
  output logic osc_clk_o
);
  logic          sync_lvl;
  logic [CW-1:0] win_lim;
  logic          filt_lvl;

  gf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (osc_raw_i),
    .q_o    (sync_lvl)
  );

  gf_win_sel #(.NARROW_CYC(NARROW_CYC), .WIDE_CYC(WIDE_CYC)) u_win (
    .sel_i (wide_sel_i),
    .lim_o (win_lim)
  );

  gf_filter #(.NARROW_CYC(NARROW_CYC), .WIDE_CYC(WIDE_CYC)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_lvl),
    .lim_i  (win_lim),
    .filt_o (filt_lvl)
  );

  // active-low enable: high passes the raw pin straight through
  assign osc_clk_o = filt_en_ni ? osc_raw_i : filt_lvl;

  assert_filt_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!filt_en_ni && !$past(filt_en_ni) && $past(filt_lvl) == filt_lvl) |-> $stable(osc_clk_o));
endmodule

// File: tb/osc_glitch_filter_test.sv
`timescale 1ns/1ps
module osc_glitch_filter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw = 1'b0;
  logic sel = 1'b0;
  logic en_n = 1'b0;
  logic out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  osc_glitch_filter uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .osc_raw_i  (raw),
    .wide_sel_i (sel),
    .filt_en_ni (en_n),
    .osc_clk_o  (out)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference: delay queue plus run length
  logic mq[$];
  logic m_out = 1'b0;
  int   m_run = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq = '{1'b0, 1'b0};
      m_out = 1'b0;
      m_run = 0;
    end else begin
      logic s;
      int win;
      s = mq.pop_front();
      mq.push_back(raw);
      win = sel ? 16 : 8;
      if (s != m_out) begin
        m_run++;
        if (m_run >= win) begin
          m_out = s;
          m_run = 0;
        end
      end else begin
        m_run = 0;
      end
      #1;
      if (rst_n) check(en_n ? "R6 per-cycle" : "R2 per-cycle", out, en_n ? raw : m_out);
    end
  end

  int rises = 0;
  int falls = 0;
  always @(posedge out) if (!en_n) rises++;
  always @(negedge out) if (!en_n) falls++;

  task automatic pulse(input logic lvl, input int n);
    @(negedge clk) raw = lvl;
    repeat (n) @(negedge clk);
    raw = ~lvl;
  endtask

  task automatic settle();
    repeat (24) @(negedge clk);
  endtask

  initial begin
    #20000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0;
    int f0;
    // R1 reset state
    #1 check("R1 in reset", out, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after reset", out, 1'b0);

    // R3 narrow window drops 7-cycle pulse
    r0 = rises;
    pulse(1'b1, 7);
    settle();
    check_int("R3 7-cycle pulse dropped", rises - r0, 0);

    // R2 8-cycle level passes, exact latency
    @(negedge clk) raw = 1'b1;
    repeat (9) @(negedge clk);
    check("R2 not yet at k+8", out, 1'b0);
    @(negedge clk);
    check("R2 flips after k+9", out, 1'b1);
    settle();

    // R8 low pulse of 7 dropped, 8 passes
    f0 = falls;
    pulse(1'b0, 7);
    settle();
    check_int("R8 7-cycle low dropped", falls - f0, 0);
    check("R8 level kept high", out, 1'b1);
    pulse(1'b0, 8);
    settle();
    check_int("R8 8-cycle low passes", falls - f0, 1);
    @(negedge clk) raw = 1'b0;
    settle();
    check("R2 back low", out, 1'b0);

    // R4 wide window
    sel = 1'b1;
    r0 = rises;
    pulse(1'b1, 15);
    settle();
    check_int("R4 15-cycle pulse dropped", rises - r0, 0);
    @(negedge clk) raw = 1'b1;
    repeat (17) @(negedge clk);
    check("R4 not yet at k+16", out, 1'b0);
    @(negedge clk);
    check("R4 flips after k+17", out, 1'b1);
    @(negedge clk) raw = 1'b0;
    settle();
    check("R4 back low", out, 1'b0);

    // R5 interrupted excursion restarts count
    sel = 1'b0;
    r0 = rises;
    @(negedge clk) raw = 1'b1;
    repeat (5) @(negedge clk);
    raw = 1'b0;
    @(negedge clk) raw = 1'b1;
    repeat (5) @(negedge clk);
    raw = 1'b0;
    settle();
    check_int("R5 split pulse dropped", rises - r0, 0);

    // R7 shrink window mid-count
    sel = 1'b1;
    @(negedge clk) raw = 1'b1;
    repeat (14) @(negedge clk);
    check("R7 still low with wide window", out, 1'b0);
    sel = 1'b0;
    @(negedge clk);
    check("R7 flips on next edge", out, 1'b1);
    @(negedge clk) raw = 1'b0;
    settle();

    // R6 bypass follows raw in same cycle
    en_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) raw = i[0];
      #0.5 check("R6 bypass", out, raw);
    end
    @(negedge clk) raw = 1'b0;
    en_n = 1'b0;
    settle();
    check("R6 filtered again", out, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule